// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit forms the 64-bit byte address for one memory access per valid pulse. A decoded mode selector chooses how the address is built. The choices are the base register alone, the base plus a displacement, the base plus a scaled index, the base plus a scaled index plus a displacement, and the next-instruction pointer plus a displacement. Two further modes handle an implicit stack push and an implicit stack pop. The index is scaled by 1, 2, 4 or 8 using a shift. The displacement arrives in a 32-bit field with a width code, and the unit sign-extends it from 8, 16 or 32 bits.

The result is registered, so it appears one clock after the input pulse. Alongside the address the unit reports a misalignment flag for the requested access size, an illegal-mode flag, and for push and pop the updated stack-pointer value with a write enable. A misaligned address is still delivered. All address arithmetic wraps modulo 2^64.

Top module: `eff_addr_unit`

## Requirements
- R1: Mode 2 gives base_i + (index_i << scale_i), and mode 3 gives base_i + (index_i << scale_i) + sext(disp). scale_i codes 0..3 mean ×1, ×2, ×4 and ×8.
- R2: Mode 0 gives addr_o = base_i unchanged, and index_i and disp_i have no effect on it.
- R3: Mode 1 gives base_i + sext(disp), and index_i has no effect on it.
- R4: The displacement width code works as follows. Code 0 sign-extends disp_i[7:0], code 1 sign-extends disp_i[15:0], and codes 2 and 3 sign-extend disp_i[31:0]. Bits above the selected width are ignored.
- R5: Mode 4 gives nip_i + sext(disp), where nip_i is the address of the next instruction.
- R6: Mode 5 (push) gives addr_o = sp_o = base_i - 8. Mode 6 (pop) gives addr_o = base_i and sp_o = base_i + 8. sp_we_o is 1 only in these two modes. In all other modes sp_we_o is 0 and sp_o is 0.
- R7: size_i codes 0..3 select 1, 2, 4 and 8 bytes. misalign_o is 1 when any of the low log2(size) bits of the address is 1. The address is output regardless.
- R8: Results and valid_o appear exactly one clock after valid_i is sampled high. Back-to-back pulses give back-to-back results. With valid_i low, valid_o is 0 and the other outputs hold their values.
- R9: Mode 7 is reserved. It gives addr_o = 0, illegal_o = 1, sp_we_o = 0 and misalign_o = 0. illegal_o is 0 for modes 0..6.
- R10: All sums and differences wrap modulo 2^64 without any indication.
- R11: While rst_ni is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| mode_i | input | 3 | Addressing mode selector (0..7) |
| base_i | input | 64 | Base register value; stack pointer in modes 5 and 6 |
| index_i | input | 64 | Index register value |
| scale_i | input | 2 | Index shift amount 0..3 |
| disp_i | input | 32 | Raw displacement field |
| disp_w_i | input | 2 | Displacement width code |
| nip_i | input | 64 | Next-instruction address |
| size_i | input | 2 | Access size code |
| valid_o | output | 1 | Result strobe |
| addr_o | output | 64 | Effective address |
| misalign_o | output | 1 | Address not aligned to access size |
| illegal_o | output | 1 | Reserved mode was requested |
| sp_we_o | output | 1 | Stack-pointer update enable |
| sp_o | output | 64 | New stack-pointer value |

## Verification
The assertions compare each result with the inputs of the cycle before it. They therefore assume that valid_i is only raised once reset has been released, and that the inputs are stable around the clock edge at which they are sampled. The stimulus changes inputs only on falling edges. It raises valid_i only after the reset release. It fills the fields that should be ignored with non-zero values, so any leakage into the address shows up. Each mode, every scale and width code, every size code, the reserved mode, and the wrap at both ends of the address space are all covered.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int ADDR_W = 64;

  typedef enum logic [2:0] {
    AM_REG   = 3'd0,
    AM_BDISP = 3'd1,
    AM_BIDX  = 3'd2,
    AM_BIDXD = 3'd3,
    AM_IPREL = 3'd4,
    AM_PUSH  = 3'd5,
    AM_POP   = 3'd6,
    AM_RSVD  = 3'd7
  } am_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              misalign;
    logic              illegal;
    logic              sp_we;
    logic [ADDR_W-1:0] sp;
  } agu_res_t;
endpackage

// File: rtl/agu_disp_ext.sv
module agu_disp_ext #(
  parameter int DISP_W = 32,
  parameter int OUT_W  = 64
) (
  input  logic [DISP_W-1:0] disp_i,
  input  logic [1:0]        wcode_i,
  output logic [OUT_W-1:0]  ext_o
);
  always_comb begin
    case (wcode_i)
      2'd0:    ext_o = {{(OUT_W-8){disp_i[7]}}, disp_i[7:0]};
      2'd1:    ext_o = {{(OUT_W-16){disp_i[15]}}, disp_i[15:0]};
      default: ext_o = {{(OUT_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
    endcase
  end
endmodule

// File: rtl/agu_index_scale.sv
module agu_index_scale #(
  parameter int W       = 64,
  parameter int SCALE_W = 2
) (
  input  logic [W-1:0]       idx_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic [W-1:0]       idx_o
);
  // shift replaces multiply; bits shifted out wrap away
  assign idx_o = idx_i << scale_i;
endmodule

// File: rtl/agu_align_chk.sv
module agu_align_chk #(
  parameter int W      = 64,
  parameter int SIZE_W = 2
) (
  input  logic [W-1:0]      addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              misalign_o
);
  localparam int MAX_LG = (1 << SIZE_W) - 1;

  logic [MAX_LG-1:0] bad_bit;

  // low bit k matters only when access spans more than 2^k bytes
  for (genvar k = 0; k < MAX_LG; k++) begin : g_bit
    assign bad_bit[k] = addr_i[k] & (size_i > SIZE_W'(k));
  end

  assign misalign_o = |bad_bit;
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
  import agu_pkg::*;
#(
  parameter int DISP_W     = 32,
  parameter int SCALE_W    = 2,
  parameter int SIZE_W     = 2,
  parameter int STACK_STEP = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [2:0]         mode_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [ADDR_W-1:0]  index_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [DISP_W-1:0]  disp_i,
  input  logic [1:0]         disp_w_i,
  input  logic [ADDR_W-1:0]  nip_i,
  input  logic [SIZE_W-1:0]  size_i,
  output logic               valid_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               misalign_o,
  output logic               illegal_o,
  output logic               sp_we_o,
  output logic [ADDR_W-1:0]  sp_o
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STACK_STEP);

  am_e               mode;
  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] idx_scaled;
  logic              mis_raw;
  agu_res_t          nxt, cur;
  logic              vld_q;

  assign mode = am_e'(mode_i);

  agu_disp_ext #(.DISP_W(DISP_W), .OUT_W(ADDR_W)) u_disp (
    .disp_i (disp_i),
    .wcode_i(disp_w_i),
    .ext_o  (disp_ext)
  );

  agu_index_scale #(.W(ADDR_W), .SCALE_W(SCALE_W)) u_scale (
    .idx_i  (index_i),
    .scale_i(scale_i),
    .idx_o  (idx_scaled)
  );

  always_comb begin
    nxt = '0;
    case (mode)
      AM_REG:   nxt.addr = base_i;
      AM_BDISP: nxt.addr = base_i + disp_ext;
      AM_BIDX:  nxt.addr = base_i + idx_scaled;
      AM_BIDXD: nxt.addr = base_i + idx_scaled + disp_ext;
      AM_IPREL: nxt.addr = nip_i + disp_ext;
      AM_PUSH: begin
        nxt.addr  = base_i - STEP_V;
        nxt.sp    = base_i - STEP_V;
        nxt.sp_we = 1'b1;
      end
      AM_POP: begin
        nxt.addr  = base_i;
        nxt.sp    = base_i + STEP_V;
        nxt.sp_we = 1'b1;
      end
      default:  nxt.illegal = 1'b1;
    endcase
    nxt.misalign = mis_raw & ~nxt.illegal;
  end

  agu_align_chk #(.W(ADDR_W), .SIZE_W(SIZE_W)) u_align (
    .addr_i    (nxt.addr),
    .size_i    (size_i),
    .misalign_o(mis_raw)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur   <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) cur <= nxt;
    end
  end

  assign valid_o    = vld_q;
  assign addr_o     = cur.addr;
  assign misalign_o = cur.misalign;
  assign illegal_o  = cur.illegal;
  assign sp_we_o    = cur.sp_we;
  assign sp_o       = cur.sp;

  AST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i)) else $error("latency"); // R8
  AST_REG_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(mode_i) == 3'd0) |-> addr_o == $past(base_i)) else $error("reg"); // R2
  AST_ILLEGAL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && illegal_o) |-> (addr_o == '0 && !sp_we_o && !misalign_o)) else $error("illegal"); // R9
  AST_PUSH_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(mode_i) == 3'd5) |-> (sp_we_o && sp_o == addr_o)) else $error("push"); // R6
  AST_POP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(mode_i) == 3'd6) |-> (sp_we_o && sp_o == addr_o + STEP_V)) else $error("pop"); // R6
  AST_BYTE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(size_i) == '0) |-> !misalign_o) else $error("byte"); // R7
endmodule

// File: tb/eff_addr_unit_tb.sv
`timescale 1ns/1ps
module eff_addr_unit_tb;
  typedef struct {
    logic [63:0] addr;
    logic        mis;
    logic        ill;
    logic        we;
    logic [63:0] sp;
    string       tag;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [63:0] base_i = '0, index_i = '0, nip_i = '0;
  logic [1:0]  scale_i = '0, disp_w_i = '0, size_i = '0;
  logic [31:0] disp_i = '0;
  logic        valid_o, misalign_o, illegal_o, sp_we_o;
  logic [63:0] addr_o, sp_o;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_err = 0;

  always #2 clk_i = ~clk_i;

  eff_addr_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .base_i(base_i), .index_i(index_i), .scale_i(scale_i), .disp_i(disp_i),
    .disp_w_i(disp_w_i), .nip_i(nip_i), .size_i(size_i), .valid_o(valid_o),
    .addr_o(addr_o), .misalign_o(misalign_o), .illegal_o(illegal_o),
    .sp_we_o(sp_we_o), .sp_o(sp_o)
  );

  function automatic logic [63:0] sx(input logic [31:0] d, input logic [1:0] w);
    if (w == 2'd0) return 64'($signed(d[7:0]));
    if (w == 2'd1) return 64'($signed(d[15:0]));
    return 64'($signed(d));
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] m, input logic [63:0] b, input logic [63:0] ix,
                       input logic [1:0] sc, input logic [31:0] d, input logic [1:0] dw,
                       input logic [63:0] ip, input logic [1:0] sz, input string tag);
    exp_t e;
    logic [63:0] si;
    si = ix * (64'd1 << sc);
    e.mis = 1'b0; e.ill = 1'b0; e.we = 1'b0; e.sp = '0; e.tag = tag;
    case (m)
      3'd0: e.addr = b;
      3'd1: e.addr = b + sx(d, dw);
      3'd2: e.addr = b + si;
      3'd3: e.addr = b + si + sx(d, dw);
      3'd4: e.addr = ip + sx(d, dw);
      3'd5: begin e.addr = b - 64'd8; e.sp = e.addr; e.we = 1'b1; end
      3'd6: begin e.addr = b; e.sp = b + 64'd8; e.we = 1'b1; end
      default: begin e.addr = '0; e.ill = 1'b1; end
    endcase
    if (!e.ill) e.mis = (e.addr % (64'd1 << sz)) != 0;
    mode_i = m; base_i = b; index_i = ix; scale_i = sc; disp_i = d;
    disp_w_i = dw; nip_i = ip; size_i = sz; valid_i = 1'b1;
    sb.push_back(e);
    @(negedge clk_i);
  endtask

  task automatic idle();
    valid_i = 1'b0;
    @(negedge clk_i);
  endtask

  // monitor: compare at falling edge, half a cycle after the output register updates
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (sb.size() == 0) begin
        check(1'b0, "R8", "unexpected valid_o", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(addr_o == e.addr, e.tag, "addr", addr_o, e.addr);
        check({misalign_o, illegal_o, sp_we_o} == {e.mis, e.ill, e.we}, e.tag, "flags",
              64'({misalign_o, illegal_o, sp_we_o}), 64'({e.mis, e.ill, e.we}));
        check(sp_o == e.sp, e.tag, "sp", sp_o, e.sp);
      end
    end
  end

  initial begin
    #(4 * 100000);
    check(1'b0, "WDOG", "timeout", 64'd0, 64'd1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] held;
    #5;
    // R11 reset state
    check({valid_o, misalign_o, illegal_o, sp_we_o} == 4'b0 && addr_o == '0 && sp_o == '0,
          "R11", "reset outputs", addr_o | sp_o, 64'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: index/disp set to junk, must not matter
    drive(3'd0, 64'h1000, 64'hDEAD, 2'd3, 32'h1234_5678, 2'd2, 64'h0, 2'd3, "R2");
    // R3 and R4 width 0, upper junk ignored (0xFC -> -4)
    drive(3'd1, 64'h2000, 64'hBEEF, 2'd1, 32'hABCD_12FC, 2'd0, 64'h0, 2'd2, "R3");
    drive(3'd1, 64'h2000, 64'h0, 2'd0, 32'h0001_8000, 2'd1, 64'h0, 2'd0, "R4");
    drive(3'd1, 64'h9000_0000, 64'h0, 2'd0, 32'h8000_0000, 2'd2, 64'h0, 2'd0, "R4");
    drive(3'd1, 64'h10, 64'h0, 2'd0, 32'h0000_0010, 2'd3, 64'h0, 2'd0, "R4");
    // R1 every scale
    drive(3'd2, 64'h4000, 64'd5, 2'd0, 32'hFFFF_FFFF, 2'd2, 64'h0, 2'd0, "R1");
    drive(3'd2, 64'h4000, 64'd5, 2'd1, 32'h0, 2'd2, 64'h0, 2'd1, "R1");
    drive(3'd2, 64'h4000, 64'd5, 2'd2, 32'h0, 2'd2, 64'h0, 2'd2, "R1");
    drive(3'd2, 64'h4000, 64'd5, 2'd3, 32'h0, 2'd2, 64'h0, 2'd3, "R1");
    drive(3'd3, 64'h4000, 64'd5, 2'd3, 32'hFFFF_FFF8, 2'd2, 64'h0, 2'd3, "R1");
    // R5 relative jump example and a backward offset
    drive(3'd4, 64'h0, 64'h0, 2'd0, 32'h0000_0006, 2'd0, 64'h612, 2'd0, "R5");
    drive(3'd4, 64'h5, 64'h7, 2'd2, 32'h0000_FF00, 2'd1, 64'h1_0000, 2'd0, "R5");
    // R6 push then pop
    drive(3'd5, 64'h7FF0, 64'h0, 2'd0, 32'h0, 2'd0, 64'h0, 2'd3, "R6");
    drive(3'd6, 64'h7FE8, 64'h0, 2'd0, 32'h0, 2'd0, 64'h0, 2'd3, "R6");
    // R7 alignment per size
    drive(3'd0, 64'h44, 64'h0, 2'd0, 32'h0, 2'd0, 64'h0, 2'd2, "R7");
    drive(3'd0, 64'h1004, 64'h0, 2'd0, 32'h0, 2'd0, 64'h0, 2'd3, "R7");
    drive(3'd0, 64'h1002, 64'h0, 2'd0, 32'h0, 2'd0, 64'h0, 2'd2, "R7");
    drive(3'd0, 64'h1001, 64'h0, 2'd0, 32'h0, 2'd0, 64'h0, 2'd1, "R7");
    drive(3'd0, 64'h1003, 64'h0, 2'd0, 32'h0, 2'd0, 64'h0, 2'd0, "R7");
    // R9 reserved mode with misaligned-looking inputs
    drive(3'd7, 64'h1003, 64'h3, 2'd1, 32'h11, 2'd0, 64'h5, 2'd3, "R9");
    // R10 wrap up and down
    drive(3'd2, 64'hFFFF_FFFF_FFFF_FFF8, 64'd1, 2'd3, 32'h0, 2'd0, 64'h0, 2'd3, "R10");
    drive(3'd5, 64'h0, 64'h0, 2'd0, 32'h0, 2'd0, 64'h0, 2'd3, "R10");
    drive(3'd4, 64'h0, 64'h0, 2'd0, 32'h0000_0080, 2'd0, 64'h10, 2'd0, "R10");
    idle();
    // R8: outputs hold while valid_i is low, even as inputs change
    held = addr_o;
    mode_i = 3'd0; base_i = 64'h5555; valid_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    check(addr_o == held && !valid_o, "R8", "hold while idle", addr_o, held);
    check(sb.size() == 0, "R8", "results outstanding", 64'(sb.size()), 64'd0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule